// File: doc/BRIEF.md
# Multiword DMA Host Engine for a Parallel Disk Bus

This block is the host side of a multiword DMA transfer on a 16-bit parallel disk interface. Software-side logic loads a word count, a transfer direction and a timing mode (0, 1 or 2), then pulses a start input. The engine waits for the drive's DMA request. It answers with an active-low acknowledge and then issues a train of active-low read or write strobes. Each strobe moves one 16-bit word.

Words read from the drive leave on a ready/valid output stream. Words written to the drive come from a ready/valid input stream. The drive can suspend a burst by withdrawing its request, and the local stream can stall. In either case the engine completes the word in flight, holds the acknowledge for the required time and releases it. It then re-arbitrates until the count is used up. At that point a one-cycle completion pulse fires. All bus timings are whole clock counts derived from nanosecond limits and the clock period parameter.

Top module: `mdma_host`

## Requirements
- R1: While reset is held and after it, acknowledge and both strobes are high (negated), the data output enable is 0, `busy`, `done` and `rdValid` are 0.
- R2: The acknowledge falls only when the drive's request was high two clocks earlier. A strobe is low only while the acknowledge is low, and the two strobes are never low together.
- R3: Each strobe stays low for exactly ceil(A/T) clocks, where T is `CLK_NS` and A is 240 ns in mode 0 and 80 ns in modes 1 and 2.
- R4: Within one acknowledge period, consecutive strobes are high for exactly ceil(N/T) clocks. N is the largest of three values: the negated-width minimum, the cycle time minus A, and the acknowledge hold time. The negated-width minimum is 240/80/40 ns for writes and 80/80/40 ns for reads in modes 0/1/2. The cycle time is 480/160/120 ns.
- R5: In a read, the bus word present when the read strobe rises is delivered on `rdData`/`rdValid`, in order, with one word per strobe.
- R6: In a write, each word accepted on `wrData` (when `wrValid` and `wrReady` are both high) is on `ddOut` with `ddOe` at 1 when its write strobe rises, in order.
- R7: A transfer issues exactly `wordCount` strobes. Then `done` pulses high for one clock, with the acknowledge already high, and `busy` returns to 0.
- R8: After the request drops, no new strobe starts until the acknowledge has been released. The engine resumes in a new acknowledge period once the request returns.
- R9: A strobe starts only when the local stream can take (read) or supply (write) a word. Otherwise the acknowledge is released and the transfer resumes later without loss or duplication.
- R10: The acknowledge rises at least ceil(H/T) clocks after the last strobe rises, with H = 20 ns in mode 0 and 5 ns otherwise. `ddOe` is 0 whenever the acknowledge is high.
- R11: A start with a word count of 0 produces the `done` pulse without ever asserting the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| mode | input | 2 | Timing mode 0..2 (3 behaves as 2) |
| dirWrite | input | 1 | 1 = host to drive, 0 = drive to host |
| wordCount | input | CW | Number of 16-bit words |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| dmarq | input | 1 | Drive DMA request, active high |
| dmackN | output | 1 | DMA acknowledge, active low |
| diorN | output | 1 | Read strobe, active low |
| diowN | output | 1 | Write strobe, active low |
| ddIn | input | 16 | Data bus from drive |
| ddOut | output | 16 | Data bus to drive |
| ddOe | output | 1 | Output enable for `ddOut` |
| rdData | output | 16 | Read word stream data |
| rdValid | output | 1 | Read word stream valid |
| rdReady | input | 1 | Read word stream ready |
| wrData | input | 16 | Write word stream data |
| wrValid | input | 1 | Write word stream valid |
| wrReady | output | 1 | Write word stream ready |

## Verification
The in-design properties watch four things on every cycle:
- strobe exclusivity and confinement to the acknowledge window;
- the exact active strobe width against the latched mode;
- the output enable never outliving the acknowledge, and the acknowledge only following a request;
- the single-cycle completion pulse, which always arrives after release.

Only the bench's scenarios can show the rest. That covers word ordering across suspended bursts, and the exact recovery gap for each direction and mode. It also covers the absence of strobes after the request drops, and lossless resumption after stream stalls.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_SETUP, S_STROBE, S_RECOV
  } mdma_state_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic       dmack;
    logic       rdStb;
    logic       wrStb;
    logic       load;
    logic       oe;
    logic       done;
    logic [1:0] mode;
  } mdma_ctl_t;

  function automatic int unsigned ceilDiv(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned activeNs(logic [1:0] m);
    return (m == 2'd0) ? 240 : 80;
  endfunction

  function automatic int unsigned cycleNs(logic [1:0] m);
    case (m)
      2'd0:    return 480;
      2'd1:    return 160;
      default: return 120;
    endcase
  endfunction

  function automatic int unsigned holdNs(logic [1:0] m);
    return (m == 2'd0) ? 20 : 5;
  endfunction

  function automatic int unsigned negMinNs(logic [1:0] m, logic wr);
    case (m)
      2'd0:    return wr ? 240 : 80;
      2'd1:    return 80;
      default: return 40;
    endcase
  endfunction

  function automatic int unsigned activeCyc(logic [1:0] m, int unsigned clkNs);
    return ceilDiv(activeNs(m), clkNs);
  endfunction

  function automatic int unsigned recoverCyc(logic [1:0] m, logic wr, int unsigned clkNs);
    int unsigned v;
    v = negMinNs(m, wr);
    if (cycleNs(m) - activeNs(m) > v) v = cycleNs(m) - activeNs(m);
    if (holdNs(m) > v) v = holdNs(m);
    return ceilDiv(v, clkNs);
  endfunction

endpackage

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned CW     = 16,
  parameter int unsigned TW     = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          dirWrite,
  input  logic [CW-1:0] wordCount,
  input  logic          dmarq,
  input  logic          wrValid,
  input  logic          rdValid,
  input  logic          rdReady,
  output logic          busy,
  output mdma_ctl_t     ctl
);

  mdma_state_t   state;
  logic [CW-1:0] remaining;
  logic [TW-1:0] timer;
  logic [1:0]    modeQ;
  logic          dirQ;
  logic          streamOk, canGo, launch, goStrobe, timerZero;
  logic [TW-1:0] actLoad, recLoad;

  always_comb begin
    streamOk  = dirQ ? wrValid : (!rdValid || rdReady);
    canGo     = dmarq && streamOk && (remaining != '0);
    timerZero = (timer == '0);
    launch    = (state == S_SETUP) || (state == S_RECOV && timerZero);
    goStrobe  = launch && canGo;
    actLoad   = TW'(activeCyc(modeQ, CLK_NS) - 1);
    recLoad   = TW'(recoverCyc(modeQ, dirQ, CLK_NS) - 1);

    ctl.dmack = (state == S_SETUP) || (state == S_STROBE) || (state == S_RECOV);
    ctl.rdStb = (state == S_STROBE) && !dirQ;
    ctl.wrStb = (state == S_STROBE) && dirQ;
    ctl.load  = goStrobe && dirQ;
    ctl.oe    = ctl.dmack && dirQ;
    ctl.done  = (state == S_ARMED) && (remaining == '0);
    ctl.mode  = modeQ;
    busy      = (state != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
      timer     <= '0;
      modeQ     <= 2'd0;
      dirQ      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_ARMED;
          remaining <= wordCount;
          modeQ     <= mode;
          dirQ      <= dirWrite;
        end
        S_ARMED: begin
          if (remaining == '0) state <= S_IDLE;
          else if (canGo)      state <= S_SETUP;
        end
        S_SETUP: begin
          if (goStrobe) begin
            state <= S_STROBE;
            timer <= actLoad;
          end else begin
            state <= S_ARMED;
          end
        end
        S_STROBE: begin
          if (timerZero) begin
            state     <= S_RECOV;
            timer     <= recLoad;
            remaining <= remaining - 1'b1;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_RECOV: begin
          if (!timerZero)    timer <= timer - 1'b1;
          else if (goStrobe) begin
            state <= S_STROBE;
            timer <= actLoad;
          end else           state <= S_ARMED;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STROBE) |-> (remaining != '0));

  // R9
  stream_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STROBE && $past(state) != S_STROBE) |->
      ($past(dirQ) ? $past(wrValid) : ($past(!rdValid) || $past(rdReady))));

endmodule

// File: rtl/mdma_dpath.sv
module mdma_dpath
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned TW     = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdma_ctl_t   ctl,
  input  logic [15:0] ddIn,
  input  logic [15:0] wrData,
  input  logic        rdReady,
  output logic        dmackN,
  output logic        diorN,
  output logic        diowN,
  output logic [15:0] ddOut,
  output logic        ddOe,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic        done
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmackN  <= 1'b1;
      diorN   <= 1'b1;
      diowN   <= 1'b1;
      ddOut   <= '0;
      ddOe    <= 1'b0;
      rdData  <= '0;
      rdValid <= 1'b0;
      done    <= 1'b0;
    end else begin
      dmackN <= !ctl.dmack;
      diorN  <= !ctl.rdStb;
      diowN  <= !ctl.wrStb;
      ddOe   <= ctl.oe;
      done   <= ctl.done;
      if (ctl.load) ddOut <= wrData;
      if (!diorN && !ctl.rdStb) begin
        rdData  <= ddIn;
        rdValid <= 1'b1;
      end else if (rdReady) begin
        rdValid <= 1'b0;
      end
    end
  end

  // Pulse-length counter used only by the width check
  logic [TW-1:0] lowCnt;
  logic          stbLow;
  assign stbLow = !diorN || !diowN;

  always_ff @(posedge clk) begin
    if (!rstN)       lowCnt <= '0;
    else if (stbLow) lowCnt <= (lowCnt == '1) ? lowCnt : lowCnt + 1'b1;
    else             lowCnt <= '0;
  end

  // R2
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!diorN && !diowN));

  // R2
  strobe_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbLow |-> !dmackN);

  // R3
  act_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stbLow && $past(stbLow)) |-> (lowCnt == TW'(activeCyc(ctl.mode, CLK_NS))));

  // R10
  oe_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ddOe |-> !dmackN);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> dmackN);

endmodule

// File: rtl/mdma_host.sv
module mdma_host
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned CW     = 16,
  parameter int unsigned TW     = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          dirWrite,
  input  logic [CW-1:0] wordCount,
  output logic          busy,
  output logic          done,
  input  logic          dmarq,
  output logic          dmackN,
  output logic          diorN,
  output logic          diowN,
  input  logic [15:0]   ddIn,
  output logic [15:0]   ddOut,
  output logic          ddOe,
  output logic [15:0]   rdData,
  output logic          rdValid,
  input  logic          rdReady,
  input  logic [15:0]   wrData,
  input  logic          wrValid,
  output logic          wrReady
);

  mdma_ctl_t ctl;

  mdma_ctrl #(.CLK_NS(CLK_NS), .CW(CW), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .dirWrite(dirWrite),
    .wordCount(wordCount), .dmarq(dmarq), .wrValid(wrValid),
    .rdValid(rdValid), .rdReady(rdReady), .busy(busy), .ctl(ctl)
  );

  mdma_dpath #(.CLK_NS(CLK_NS), .TW(TW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ddIn(ddIn), .wrData(wrData),
    .rdReady(rdReady), .dmackN(dmackN), .diorN(diorN), .diowN(diowN),
    .ddOut(ddOut), .ddOe(ddOe), .rdData(rdData), .rdValid(rdValid), .done(done)
  );

  assign wrReady = ctl.load;

  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmackN) |-> $past(dmarq, 2));

endmodule

// File: tb/test_mdma_host.sv
module test_mdma_host;
  localparam int CLK_NS = 8;
  localparam int CW     = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          dirWrite = 1'b0;
  logic [CW-1:0] wordCount = '0;
  logic          busy, done;
  logic          dmarq = 1'b0;
  logic          dmackN, diorN, diowN;
  logic [15:0]   ddIn = '0;
  logic [15:0]   ddOut;
  logic          ddOe;
  logic [15:0]   rdData;
  logic          rdValid;
  logic          rdReady = 1'b0;
  logic [15:0]   wrData = '0;
  logic          wrValid = 1'b0;
  logic          wrReady;

  always #4 clk = ~clk;

  mdma_host #(.CLK_NS(CLK_NS), .CW(CW)) i_mdma_host (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .dirWrite(dirWrite),
    .wordCount(wordCount), .busy(busy), .done(done), .dmarq(dmarq),
    .dmackN(dmackN), .diorN(diorN), .diowN(diowN), .ddIn(ddIn), .ddOut(ddOut),
    .ddOe(ddOe), .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady)
  );

  int nTests = 0;
  int nFail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cdiv(input int a);
    return (a + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int expActive(input int m);
    return cdiv(m == 0 ? 240 : 80);
  endfunction

  function automatic int expRecover(input int m, input bit wr);
    int cycT, actT, negT, holdT, v;
    cycT  = (m == 0) ? 480 : (m == 1) ? 160 : 120;
    actT  = (m == 0) ? 240 : 80;
    negT  = (m == 0) ? (wr ? 240 : 80) : (m == 1) ? 80 : 40;
    holdT = (m == 0) ? 20 : 5;
    v = negT;
    if (cycT - actT > v) v = cycT - actT;
    if (holdT > v) v = holdT;
    return cdiv(v);
  endfunction

  function automatic int expHold(input int m);
    return cdiv(m == 0 ? 20 : 5);
  endfunction

  task automatic runOne(input int m, input bit wr, input int count,
                        input int dropEvery, input bit stall);
    int strobes = 0, burstStrobes = 0, bursts = 0, lowCnt = 0, lastRise = 0;
    int ackFalls = 0, afterDrop = 0, devIdx = 0, srcIdx = 0, rcvIdx = 0;
    int doneCnt = 0, postCnt = 0, raiseCnt = 0, cyc = 0;
    bit pendW = 0, doneSeen = 0, prevStb = 0, prevAck = 1, stbLow;
    int eAct, eRec, eHold;
    string tag;
    eAct  = expActive(m);
    eRec  = expRecover(m, wr);
    eHold = expHold(m);
    tag   = $sformatf("m%0d %s n%0d", m, wr ? "wr" : "rd", count);

    @(negedge clk);
    mode = 2'(m); dirWrite = wr; wordCount = CW'(count); start = 1'b1; dmarq = 1'b1;
    wrData = 16'h3300; wrValid = wr && (count > 0); rdReady = 1'b1; ddIn = 16'h5A00;
    @(negedge clk);
    start = 1'b0;

    while (cyc < 30000 && !(doneSeen && postCnt >= 12)) begin
      if (pendW) begin srcIdx++; pendW = 0; end
      stbLow = !diorN || !diowN;
      if (stbLow && !prevStb) begin
        if (!dmarq) afterDrop++;
        if (burstStrobes > 0) check(cyc - lastRise == eRec, "R4", {tag, " gap"}, cyc - lastRise, eRec);
      end
      if (stbLow) lowCnt++;
      if (!stbLow && prevStb) begin
        check(lowCnt == eAct, "R3", {tag, " active width"}, lowCnt, eAct);
        lowCnt = 0; strobes++; burstStrobes++; lastRise = cyc;
        if (wr) begin
          check(ddOut == 16'(16'h3300 + devIdx) && ddOe, "R6", {tag, " write word"},
                int'(ddOut), 16'h3300 + devIdx);
        end
        devIdx++;
        if (dropEvery > 0 && burstStrobes % dropEvery == 0) begin
          dmarq = 1'b0; raiseCnt = 0;
        end
      end
      if (!dmackN && prevAck) ackFalls++;
      if (dmackN && !prevAck) begin
        bursts++;
        check(cyc - lastRise >= eHold, "R10", {tag, " ack hold"}, cyc - lastRise, eHold);
        check(!ddOe, "R10", {tag, " oe released"}, int'(ddOe), 0);
        burstStrobes = 0;
      end
      if (!dmarq) begin
        if (dmackN) raiseCnt++;
        if (raiseCnt >= 4) dmarq = 1'b1;
      end
      ddIn = 16'(16'h5A00 + devIdx);
      if (doneSeen) postCnt++;
      if (done) begin
        doneCnt++; doneSeen = 1;
        check(dmackN, "R7", {tag, " ack high at done"}, int'(dmackN), 1);
      end
      wrValid = wr && (srcIdx < count) && (!stall || (cyc % 16) < 8);
      wrData  = 16'(16'h3300 + srcIdx);
      rdReady = !stall || ((cyc % 16) < 8);
      prevStb = stbLow; prevAck = dmackN;
      #1;
      if (wr && wrValid && wrReady) pendW = 1;
      if (!wr && rdValid && rdReady) begin
        check(rdData == 16'(16'h5A00 + rcvIdx), "R5", {tag, " read word"},
              int'(rdData), 16'h5A00 + rcvIdx);
        rcvIdx++;
      end
      @(negedge clk);
      cyc++;
    end

    check(doneSeen, "R7", {tag, " done seen"}, int'(doneSeen), 1);
    check(doneCnt == 1, "R7", {tag, " done pulses"}, doneCnt, 1);
    check(strobes == count, "R7", {tag, " strobe count"}, strobes, count);
    check(dmackN && !busy, "R7", {tag, " idle after"}, int'(busy), 0);
    if (wr) check(srcIdx == count, stall ? "R9" : "R6", {tag, " words taken"}, srcIdx, count);
    else    check(rcvIdx == count, stall ? "R9" : "R5", {tag, " words delivered"}, rcvIdx, count);
    if (dropEvery > 0 && count > dropEvery) begin
      check(bursts >= 2, "R8", {tag, " resumed bursts"}, bursts, 2);
      check(afterDrop == 0, "R8", {tag, " strobes after drop"}, afterDrop, 0);
    end
    if (count == 0) check(ackFalls == 0, "R11", {tag, " no ack"}, ackFalls, 0);
    dmarq = 1'b0; wrValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(dmackN && diorN && diowN && !ddOe && !busy && !done && !rdValid,
          "R1", "reset outputs", int'(ddOe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(dmackN && diorN && diowN && !ddOe && !busy && !done && !rdValid,
          "R1", "idle after reset", int'(busy), 0);

    for (int m = 0; m < 3; m++) begin
      for (int w = 0; w < 2; w++) begin
        runOne(m, w[0], 6, 0, 1'b0);
        runOne(m, w[0], 7, 3, 1'b0);
        runOne(m, w[0], 6, 0, 1'b1);
        runOne(m, w[0], 5, 2, 1'b1);
      end
    end
    runOne(0, 1'b0, 0, 0, 1'b0);
    runOne(2, 1'b1, 0, 0, 1'b0);
    runOne(1, 1'b0, 1, 0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule